// File: doc/BRIEF.md
# Open-Drain Data Line Direction Arbiter

This block sits between one open-drain data line of a smart card and the matching open-drain line on the host side. No pin tells it which way data flows. It samples both lines every clock. Whichever line is pulled low first, with the other line still high, becomes the driving side. The block then pulls the other line low after a programmable number of cycles. Each direction has its own delay: card to host is slow, and host to card is fast.

The direction stays fixed while the driving side is low. During that time, lows seen on the driven side are ignored, and this includes the block's own echo. When the driving side returns high, the driven side is released at once. One guard cycle follows, and then the arbiter goes back to neutral. If both lines fall in the same sample, no direction is chosen.

An inactive-session input forces the card side to be pulled low, keeps the host side released, and parks the state machine in its guard state. One copy of the block is used per data line, and more copies can serve the auxiliary lines.

Top module: `io_dir_arbiter`

## Requirements
- R1: After synchronous reset, with the session active and both lines high, `card_pull` and `host_pull` are 0.
- R2: If the first clock edge that samples `card_in` low (edge 0) also samples `host_in` high, `host_pull` is 1 after each edge k with C2H_DLY+2 <= k <= L. Here L is the first edge that samples `card_in` high again.
- R3: The same rule holds from host to card. `card_pull` is 1 for edges H2C_DLY+2 through L, where edge 0 is the first edge that samples `host_in` low while `card_in` is high.
- R4: While the card side is driving, lows on `host_in`, including the block's own echo, never assert `card_pull`. The reverse also holds.
- R5: If edge L is the first edge to sample the driving line high, the driven pull is 0 from edge L+1 onward.
- R6: After a transfer ends, the echo still sampled on the driven line does not start a transfer in the opposite direction. Both pulls stay 0 until a new external low arrives.
- R7: If both lines are first sampled low on the same edge, neither pull is asserted while both stay low.
- R8: If the driving side releases before its forwarding delay has elapsed, the driven pull is never asserted.
- R9: While `sess_active` is 0, `card_pull` is 1 and `host_pull` is 0 from the next edge on, whatever the line levels. After `sess_active` returns to 1, `card_pull` is 0 after the next edge and no transfer starts from the released card line.
- R10: `card_pull` and `host_pull` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sess_active | input | 1 | 1 while a card session is active |
| card_in | input | 1 | Sampled level of the card data line (1 = high) |
| host_in | input | 1 | Sampled level of the host data line (1 = high) |
| card_pull | output | 1 | Registered pull-low enable for the card line |
| host_pull | output | 1 | Registered pull-low enable for the host line |

## Verification
Count edges from the first edge that samples a falling line. The forwarded pull appears after edge delay+2: one edge for the input register, one to choose a direction, and the delay counter before the output register. The pull drops one edge after the release is sampled. The bench models each line as a wired-AND of an external driver and the block's own pull. It checks both pulls one time unit after every rising edge, and it compares them with a window computed from the hold length and the delay. Hold lengths are swept from shorter than the delay to longer than it, in both directions.

// File: rtl/io_arb_pkg.sv
package io_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CARD  = 2'd1,
    ST_HOST  = 2'd2,
    ST_GUARD = 2'd3
  } arb_state_t;
endpackage

// File: rtl/io_line_sampler.sv
module io_line_sampler #(
  parameter int N_LINES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] lines_in,
  output logic [N_LINES-1:0] lines_q
);
  // One register per line; lines idle high, so reset to 1
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) lines_q[i] <= 1'b1;
      else     lines_q[i] <= lines_in[i];
    end
  end
endmodule

// File: rtl/io_fwd_timer.sv
module io_fwd_timer #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic done
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !go)     cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIMIT);

  p_count_rises_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(go));
endmodule

// File: rtl/io_dir_fsm.sv
module io_dir_fsm
  import io_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sess_active,
  input  logic       card_s,
  input  logic       host_s,
  output arb_state_t state
);
  arb_state_t state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: begin
        if (!card_s && host_s)      state_nx = ST_CARD;
        else if (!host_s && card_s) state_nx = ST_HOST;
      end
      ST_CARD:  if (card_s) state_nx = ST_GUARD;
      ST_HOST:  if (host_s) state_nx = ST_GUARD;
      ST_GUARD: state_nx = ST_IDLE;
      default:  state_nx = ST_GUARD;
    endcase
    if (!sess_active) state_nx = ST_GUARD;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_GUARD;
    else     state <= state_nx;
  end

  p_tie_stays_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !card_s && !host_s) |=> (state == ST_IDLE || state == ST_GUARD));
  p_release_to_guard_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CARD && card_s) |=> (state == ST_GUARD));
  p_host_release_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOST && host_s) |=> (state == ST_GUARD));
  p_inactive_park_r9: assert property (@(posedge clk) disable iff (rst)
    !sess_active |=> (state == ST_GUARD));
endmodule

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter
  import io_arb_pkg::*;
#(
  parameter int C2H_DLY = 4,
  parameter int H2C_DLY = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sess_active,
  input  logic card_in,
  input  logic host_in,
  output logic card_pull,
  output logic host_pull
);
  logic [1:0] lines_q;
  logic       card_s, host_s;
  arb_state_t state;
  logic       c2h_done, h2c_done;

  io_line_sampler #(.N_LINES(2)) u_smp (
    .clk(clk), .rst(rst),
    .lines_in({host_in, card_in}),
    .lines_q(lines_q)
  );
  assign card_s = lines_q[0];
  assign host_s = lines_q[1];

  io_dir_fsm u_fsm (
    .clk(clk), .rst(rst), .sess_active(sess_active),
    .card_s(card_s), .host_s(host_s), .state(state)
  );

  io_fwd_timer #(.DLY(C2H_DLY)) u_c2h (
    .clk(clk), .rst(rst), .go(state == ST_CARD), .done(c2h_done)
  );
  io_fwd_timer #(.DLY(H2C_DLY)) u_h2c (
    .clk(clk), .rst(rst), .go(state == ST_HOST), .done(h2c_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      card_pull <= 1'b0;
      host_pull <= 1'b0;
    end else if (!sess_active) begin
      card_pull <= 1'b1;
      host_pull <= 1'b0;
    end else begin
      host_pull <= (state == ST_CARD) && c2h_done && !card_s;
      card_pull <= (state == ST_HOST) && h2c_done && !host_s;
    end
  end

  p_one_dir_r10: assert property (@(posedge clk) disable iff (rst)
    !(card_pull && host_pull));
  p_inactive_pins_r9: assert property (@(posedge clk) disable iff (rst)
    !sess_active |=> (card_pull && !host_pull));
  p_host_pull_src_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(host_pull) |-> $past(!card_s));
  p_card_pull_src_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(card_pull) && $past(sess_active)) |-> $past(!host_s));
endmodule

// File: tb/io_dir_arbiter_test.sv
module io_dir_arbiter_test;
  localparam int CLK_P = 10;
  localparam int C2H   = 3;
  localparam int H2C   = 1;
  localparam int MAXL  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sess_active = 1'b1;
  logic card_ext = 1'b1;
  logic host_ext = 1'b1;
  logic card_pull, host_pull;
  logic card_in, host_in;

  // wired-AND line models: external driver and the block's own pull
  assign card_in = card_ext & ~card_pull;
  assign host_in = host_ext & ~host_pull;

  always #(CLK_P/2) clk = ~clk;

  io_dir_arbiter #(.C2H_DLY(C2H), .H2C_DLY(H2C)) uut (
    .clk(clk), .rst(rst), .sess_active(sess_active),
    .card_in(card_in), .host_in(host_in),
    .card_pull(card_pull), .host_pull(host_pull)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // One transfer: driving side held low for len sampling edges (edges 0..len-1)
  task automatic xfer(input bit from_card, input int len);
    int dly;
    string lbl;
    logic exp_fwd;
    dly = from_card ? C2H : H2C;
    @(negedge clk);
    if (from_card) card_ext = 1'b0; else host_ext = 1'b0;
    for (int k = 0; k <= len + 4; k++) begin
      @(posedge clk); #1;
      exp_fwd = (k >= dly + 2) && (k <= len);
      if (k == len + 1)        lbl = "R5";
      else if (k > len)        lbl = "R6";
      else if (len < dly + 2)  lbl = "R8";
      else                     lbl = from_card ? "R2" : "R3";
      if (from_card) begin
        chk(host_pull, exp_fwd, lbl);
        chk(card_pull, 1'b0, (k <= len) ? "R4" : "R6");
      end else begin
        chk(card_pull, exp_fwd, lbl);
        chk(host_pull, 1'b0, (k <= len) ? "R4" : "R6");
      end
      if (k == len - 1) begin
        if (from_card) card_ext = 1'b1; else host_ext = 1'b1;
      end
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(card_pull, 1'b0, "R1");
      chk(host_pull, 1'b0, "R1");
    end

    // sweep hold lengths in both directions
    for (int len = 1; len <= MAXL; len++) begin
      xfer(1'b1, len);
      xfer(1'b0, len);
    end

    // R4: external host pulse during a card-driven transfer
    @(negedge clk); card_ext = 1'b0;
    for (int k = 0; k <= 12; k++) begin
      @(posedge clk); #1;
      chk(host_pull, (k >= C2H + 2) && (k <= 10), "R4");
      chk(card_pull, 1'b0, "R4");
      if (k == C2H + 3) host_ext = 1'b0;
      if (k == C2H + 5) host_ext = 1'b1;
      if (k == 9) card_ext = 1'b1;
    end

    // R7: both lines fall in the same sample
    @(negedge clk); card_ext = 1'b0; host_ext = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      chk(card_pull, 1'b0, "R7");
      chk(host_pull, 1'b0, "R7");
    end
    @(negedge clk); card_ext = 1'b1; host_ext = 1'b1;
    repeat (3) @(posedge clk);
    xfer(1'b1, 5);

    // R9: session inactive forces card low, host released
    @(negedge clk); sess_active = 1'b0; host_ext = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk(card_pull, 1'b1, "R9");
      chk(host_pull, 1'b0, "R9");
    end
    @(negedge clk); host_ext = 1'b1;
    @(posedge clk); #1;
    chk(card_pull, 1'b1, "R9");
    @(negedge clk); sess_active = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(posedge clk); #1;
      chk(card_pull, 1'b0, "R9");
      chk(host_pull, 1'b0, "R9");
    end
    xfer(1'b0, 4);
    xfer(1'b1, 6);

    finish_run();
  end
endmodule